// File: doc/BRIEF.md
# Multiplexed-Address EDO DRAM Device Model

This block is a clock-sampled, synthesizable model of an asynchronous DRAM with extended-data-out behaviour. A DRAM controller under verification connects to it. The model samples the active-low row strobe, column strobe, write enable and output enable once per system clock. It finds strobe edges by comparing each sample with the one taken on the clock before. A single address bus carries the row at the row-strobe fall and the column at the column-strobe fall. The bidirectional data bus is split into a data input, a data output and an output-drive flag.

The storage array is a grid of rows by columns of bytes. Reads, writes, page-mode bursts within one open row and read-modify-write all go through the column strobe. If the column strobe falls while the row strobe is high, the next row-strobe fall becomes a refresh of the row chosen by an internal counter instead of an access. Charge loss is not modelled in time. Each row only carries a flag that is set when the row is refreshed or activated. A refresh that is abandoned raises a sticky protocol-error flag.

Top module: `edo_dram_model`

## Requirements
- R1: After reset: `dout_en` = 0, `ref_pulse` = 0, `ref_ptr` = 0, `row_fresh` = 0 and `proto_err` = 0.
- R2: A row-strobe fall latches the row from `addr`. A later column-strobe fall with `we_n` = 1 latches the column from `addr` and loads the stored byte at that row and column onto `dout`. `dout` and `dout_en` are valid from the clock after the sample that first shows the fall.
- R3: A column-strobe fall with `we_n` = 0 writes `din`, sampled at that same clock, into the open row at the column on `addr`. At most one of read, write and refresh happens per clock.
- R4: While the row strobe stays low, each further column-strobe fall performs another read or write in the same row with a new column (page mode).
- R5: Read data stays driven (`dout_en` = 1) after the column strobe rises. A row-strobe rise releases it on the next clock.
- R6: `dout_en` is 1 only while `oe_n` was low at the previous sample. Raising `oe_n` releases the data. Lowering `oe_n` again does not re-drive it. A column-strobe fall that is not a read also releases it.
- R7: In read-modify-write, a read is followed by a fall of `we_n` while the column strobe is still low. This writes `din` to the same row and column and releases `dout`.
- R8: A column-strobe fall while the row strobe is high, followed by a row-strobe fall, refreshes row `ref_ptr`. That row's `row_fresh` bit is set, `ref_pulse` is high for one clock, `ref_ptr` increments, and no array access takes place.
- R9: `ref_ptr` steps through all rows in order and wraps from the last row to row 0.
- R10: If a pending refresh is abandoned, `proto_err` goes to 1 and stays there until reset. A refresh is pending once the column strobe has fallen with the row strobe high. It is abandoned if the column strobe rises while the row strobe is still high. An abandoned refresh does not advance `ref_ptr`.
- R11: Activating a row with a row-strobe fall sets that row's `row_fresh` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (4) | Multiplexed row/column address |
| din | input | DW (8) | Write data |
| dout | output | DW (8) | Read data |
| dout_en | output | 1 | High while `dout` is driven |
| ref_pulse | output | 1 | One-clock pulse for each completed refresh |
| ref_ptr | output | ROW_W (4) | Row the next refresh will use |
| row_fresh | output | ROWS (16) | Per-row flag, set by refresh or activation |
| proto_err | output | 1 | Sticky abandoned-refresh flag |

## Verification
Every result is registered at the first rising clock edge whose sample shows the causing strobe change. Read data, drive flag, refresh pulse, counter, row flags and error flag are therefore all due one clock after the stimulus. The bench changes inputs just after a falling clock edge and reads outputs at the following falling edge, so exactly one rising edge lies between stimulus and check. Checks that a result holds, such as data kept after the column strobe rises or the error flag staying set, are taken one further falling edge later with no new stimulus in between.

// File: rtl/edo_dram_pkg.sv
// Package: shared constants for the EDO DRAM model.
// Assumes: strobe vectors are packed in the index order given here.
package edo_dram_pkg;
    // Positions of strobes inside the sampled strobe vector
    localparam int unsigned STB_RAS = 0;
    localparam int unsigned STB_CAS = 1;
    localparam int unsigned STB_NUM = 2;
endpackage

// File: rtl/edo_edge_det.sv
// Module: edge finder for active-low strobes sampled on the system clock.
// Does: keeps the previous sample of each strobe and reports a fall or rise
// combinationally in the cycle a new sample differs from the stored one.
// Assumes: inputs are already synchronous to clk; idle level is high.
module edo_edge_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Remember the last sample of this strobe (idle high after reset)
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= lvl[g];
        end
    end

    // Compare current sample with the remembered one
    always_comb begin
        fall = prev_q & ~lvl;
        rise = ~prev_q & lvl;
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
// Module: strobe-sequence decoder of the DRAM model.
// Does: latches the row, opens and closes it, turns column-strobe falls into
// read or write commands, arms and runs strobe-order refresh with an internal
// row counter, keeps per-row refreshed flags and a sticky protocol error.
// Assumes: edges come from edo_edge_det on the same clock; a row and a column
// strobe fall never arrive in the same sample.
module edo_dram_ctrl #(
    parameter int unsigned ROW_W = 4,
    parameter int unsigned COL_W = 4,
    parameter int unsigned AW    = 4,
    localparam int unsigned ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic             cas_fall,
    input  logic             cas_rise,
    input  logic             we_fall,
    input  logic             we_rise,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic [ROW_W-1:0] acc_row,
    output logic [COL_W-1:0] acc_col,
    output logic             ref_pulse,
    output logic [ROW_W-1:0] ref_ptr,
    output logic [ROWS-1:0]  row_fresh,
    output logic             proto_err
);
    logic             row_open;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             rd_live;
    logic             cbr_arm;
    logic [ROW_W-1:0] ref_cnt;
    logic             ref_pulse_q;
    logic             err_q;
    logic [ROWS-1:0]  fresh_q;
    logic             ref_go;

    // Decode this sample's strobe edges into one command
    always_comb begin
        ref_go  = ras_fall & cbr_arm;
        acc_rd  = cas_fall & row_open & ~ras_n & we_n;
        acc_wr  = (cas_fall & row_open & ~ras_n & ~we_n)
                | (we_fall & rd_live & ~cas_n & ~cas_fall);
        acc_row = row_q;
        acc_col = cas_fall ? addr[COL_W-1:0] : col_q;
    end

    // Row, column, refresh and error state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open    <= 1'b0;
            row_q       <= '0;
            col_q       <= '0;
            rd_live     <= 1'b0;
            cbr_arm     <= 1'b0;
            ref_cnt     <= '0;
            ref_pulse_q <= 1'b0;
            err_q       <= 1'b0;
            fresh_q     <= '0;
        end else begin
            ref_pulse_q <= ref_go;
            if (ref_go) begin
                fresh_q[ref_cnt] <= 1'b1;
                ref_cnt          <= ref_cnt + 1'b1;
                cbr_arm          <= 1'b0;
            end else if (ras_fall) begin
                row_q                      <= addr[ROW_W-1:0];
                row_open                   <= 1'b1;
                fresh_q[addr[ROW_W-1:0]]   <= 1'b1;
            end
            if (ras_rise) row_open <= 1'b0;
            if (cas_fall && ras_n) cbr_arm <= 1'b1;
            if (cbr_arm && cas_rise && ras_n) begin
                err_q   <= 1'b1;
                cbr_arm <= 1'b0;
            end
            if (cas_fall) col_q <= addr[COL_W-1:0];
            if (acc_rd) rd_live <= 1'b1;
            if (acc_wr || cas_rise || ras_rise) rd_live <= 1'b0;
        end
    end

    assign ref_pulse = ref_pulse_q;
    assign ref_ptr   = ref_cnt;
    assign row_fresh = fresh_q;
    assign proto_err = err_q;

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_rd, acc_wr, ref_go}));                           // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_go |=> $stable(ref_ptr));                                 // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);                                      // R10
    AST_RMW_NO_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        we_rise |-> !acc_wr);                                          // R7
endmodule

// File: rtl/edo_dram_store.sv
// Module: storage array and extended-data-out read register.
// Does: writes bytes on write commands, loads read bytes on read commands and
// keeps them driven until the row closes, output enable rises or another
// non-read column access starts.
// Assumes: at most one command per clock; the array itself has no reset.
module edo_dram_store #(
    parameter int unsigned ROW_W = 4,
    parameter int unsigned COL_W = 4,
    parameter int unsigned DW    = 8,
    localparam int unsigned IW    = ROW_W + COL_W,
    localparam int unsigned DEPTH = 1 << IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic [DW-1:0]    din,
    input  logic             oe_n,
    input  logic             ras_rise,
    input  logic             cas_fall,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);
    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx;
    logic [DW-1:0] dout_q;
    logic          en_q;

    assign idx = {acc_row, acc_col};

    // Array write port
    always_ff @(posedge clk) begin
        if (acc_wr) mem[idx] <= din;
    end

    // Read register and drive flag with extended hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (acc_rd) dout_q <= mem[idx];
            if (ras_rise || oe_n)       en_q <= 1'b0;
            else if (acc_rd)            en_q <= 1'b1;
            else if (acc_wr || cas_fall) en_q <= 1'b0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = en_q;

    AST_EN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!oe_n));                                     // R6
    AST_RAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ras_rise |=> !dout_en);                                        // R5
    AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !dout_en);                                          // R7
endmodule

// File: rtl/edo_dram_model.sv
// Module: top of the multiplexed-address EDO DRAM model.
// Does: samples the strobes, finds their edges, decodes the strobe order and
// drives the storage array and read register.
// Assumes: all inputs change away from the rising clock edge; strobes are
// held at least one clock per level so every edge is seen.
module edo_dram_model #(
    parameter int unsigned ROW_W = 4,
    parameter int unsigned COL_W = 4,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int unsigned ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en,
    output logic             ref_pulse,
    output logic [ROW_W-1:0] ref_ptr,
    output logic [ROWS-1:0]  row_fresh,
    output logic             proto_err
);
    import edo_dram_pkg::*;

    logic [STB_NUM-1:0] stb_lvl;
    logic [STB_NUM-1:0] stb_fall;
    logic [STB_NUM-1:0] stb_rise;
    logic               we_fall;
    logic               we_rise;
    logic               acc_rd;
    logic               acc_wr;
    logic [ROW_W-1:0]   acc_row;
    logic [COL_W-1:0]   acc_col;

    // Pack address strobes in package order
    always_comb begin
        stb_lvl          = '1;
        stb_lvl[STB_RAS] = ras_n;
        stb_lvl[STB_CAS] = cas_n;
    end

    edo_edge_det #(.W(STB_NUM)) u_stb_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb_lvl),
        .fall  (stb_fall),
        .rise  (stb_rise)
    );

    edo_edge_det #(.W(1)) u_we_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (we_n),
        .fall  (we_fall),
        .rise  (we_rise)
    );

    edo_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ras_fall  (stb_fall[STB_RAS]),
        .ras_rise  (stb_rise[STB_RAS]),
        .cas_fall  (stb_fall[STB_CAS]),
        .cas_rise  (stb_rise[STB_CAS]),
        .we_fall   (we_fall),
        .we_rise   (we_rise),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_row   (acc_row),
        .acc_col   (acc_col),
        .ref_pulse (ref_pulse),
        .ref_ptr   (ref_ptr),
        .row_fresh (row_fresh),
        .proto_err (proto_err)
    );

    edo_dram_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .acc_row  (acc_row),
        .acc_col  (acc_col),
        .din      (din),
        .oe_n     (oe_n),
        .ras_rise (stb_rise[STB_RAS]),
        .cas_fall (stb_fall[STB_CAS]),
        .dout     (dout),
        .dout_en  (dout_en)
    );
endmodule

// File: tb/edo_dram_model_bench.sv
module edo_dram_model_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 10;
    // {write, row[3:0], col[3:0], data[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 4'd2,  4'd5,  8'hA5},
        {1'b1, 4'd2,  4'd6,  8'h3C},
        {1'b1, 4'd15, 4'd15, 8'hFF},
        {1'b1, 4'd0,  4'd0,  8'h01},
        {1'b0, 4'd2,  4'd5,  8'hA5},
        {1'b0, 4'd2,  4'd6,  8'h3C},
        {1'b0, 4'd15, 4'd15, 8'hFF},
        {1'b0, 4'd0,  4'd0,  8'h01},
        {1'b1, 4'd2,  4'd5,  8'h77},
        {1'b0, 4'd2,  4'd5,  8'h77}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        ref_pulse;
    logic [3:0]  ref_ptr;
    logic [15:0] row_fresh;
    logic        proto_err;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_dram_model u_edo_dram_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .ref_pulse(ref_pulse), .ref_ptr(ref_ptr), .row_fresh(row_fresh),
        .proto_err(proto_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic row_dn(input logic [3:0] r);
        addr = r; ras_n = 1'b0; @(negedge clk);
    endtask
    task automatic row_up();
        ras_n = 1'b1; @(negedge clk);
    endtask
    task automatic col_rd(input logic [3:0] c);
        addr = c; we_n = 1'b1; cas_n = 1'b0; @(negedge clk);
    endtask
    task automatic col_wr(input logic [3:0] c, input logic [7:0] d);
        addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; @(negedge clk);
    endtask
    task automatic col_up();
        cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
    endtask

    task automatic rd_one(input logic [3:0] r, input logic [3:0] c, input logic [7:0] exp, input string tag);
        row_dn(r); col_rd(c);
        chk(tag, {dout_en, dout}, {1'b1, exp});
        col_up(); row_up();
    endtask

    task automatic cbr_refresh();
        cas_n = 1'b0; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 dout_en", dout_en, 0);
        chk("R1 ref_pulse", ref_pulse, 0);
        chk("R1 ref_ptr", ref_ptr, 0);
        chk("R1 row_fresh", row_fresh, 0);
        chk("R1 proto_err", proto_err, 0);

        // R2 / R3 table of single writes and reads
        for (int i = 0; i < NVEC; i++) begin
            row_dn(VEC[i][15:12]);
            if (VEC[i][16]) begin
                col_wr(VEC[i][11:8], VEC[i][7:0]);
                chk("R3 write releases", dout_en, 0);
            end else begin
                col_rd(VEC[i][11:8]);
                chk("R2 read data", {dout_en, dout}, {1'b1, VEC[i][7:0]});
            end
            col_up(); row_up();
            @(negedge clk);
        end

        // R4 / R5 page mode in row 2
        row_dn(4'd2);
        col_rd(4'd6);
        chk("R4 page rd1", {dout_en, dout}, {1'b1, 8'h3C});
        col_up();
        chk("R5 hold after cas rise", {dout_en, dout}, {1'b1, 8'h3C});
        col_rd(4'd5);
        chk("R4 page rd2", {dout_en, dout}, {1'b1, 8'h77});
        col_up();
        col_wr(4'd7, 8'h5A);
        chk("R6 write cas releases", dout_en, 0);
        col_up();
        col_rd(4'd6);
        col_up();
        row_up();
        chk("R5 ras rise releases", dout_en, 0);
        rd_one(4'd2, 4'd7, 8'h5A, "R4 page write stored");

        // R6 output enable
        row_dn(4'd15);
        col_rd(4'd15);
        chk("R6 driven", dout_en, 1);
        oe_n = 1'b1; @(negedge clk);
        chk("R6 oe high releases", dout_en, 0);
        oe_n = 1'b0; @(negedge clk);
        chk("R6 oe low no redrive", dout_en, 0);
        col_up(); row_up();
        oe_n = 1'b1;
        row_dn(4'd0); col_rd(4'd0);
        chk("R6 read with oe high", dout_en, 0);
        col_up(); row_up();
        oe_n = 1'b0;

        // R7 read-modify-write
        row_dn(4'd0);
        col_rd(4'd0);
        chk("R7 rmw read", {dout_en, dout}, {1'b1, 8'h01});
        din = 8'hC3; we_n = 1'b0; @(negedge clk);
        chk("R7 rmw write releases", dout_en, 0);
        col_up(); row_up();
        rd_one(4'd0, 4'd0, 8'hC3, "R7 rmw stored");

        // R11 activation marks row
        do_reset();
        row_dn(4'd9);
        chk("R11 activation flag", row_fresh, 16'h0200);
        row_up();

        // R8 one refresh
        cbr_refresh();
        chk("R8 ref pulse", ref_pulse, 1);
        chk("R8 ptr step", ref_ptr, 1);
        chk("R8 row flag", row_fresh, 16'h0201);
        ras_n = 1'b1; cas_n = 1'b1; @(negedge clk);
        chk("R8 pulse one clock", ref_pulse, 0);
        chk("R8 no error", proto_err, 0);
        rd_one(4'd0, 4'd0, 8'hC3, "R8 data kept");

        // R9 wrap of the counter
        for (int k = 0; k < 15; k++) begin
            cbr_refresh();
            ras_n = 1'b1; cas_n = 1'b1; @(negedge clk);
        end
        chk("R9 wrap to zero", ref_ptr, 0);
        chk("R9 all rows flagged", row_fresh, 16'hFFFF);
        cbr_refresh();
        chk("R9 after wrap", ref_ptr, 1);
        ras_n = 1'b1; cas_n = 1'b1; @(negedge clk);

        // R10 abandoned refresh
        cas_n = 1'b0; @(negedge clk);
        cas_n = 1'b1; @(negedge clk);
        chk("R10 error set", proto_err, 1);
        chk("R10 no refresh", ref_ptr, 1);
        @(negedge clk);
        chk("R10 sticky", proto_err, 1);
        do_reset();
        chk("R1 error cleared", proto_err, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule